// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs bus cycles on an external bus for a 16-bit processor core. A transfer request arrives on a valid/ready port. The controller then runs four clock states, T1 to T4. The shared address/data lanes carry the low address bits in T1 and the data in T2, T3 and T4. A separate 20-bit address bus carries the whole address. It is updated on the falling clock edge before T1, so it is valid half a clock before the shared lanes show the address. An address-latch strobe rises at the start of T1 and falls at mid-T1, while the address on the lanes is steady. One write-enable per byte lane selects the lanes that drive data.

A two-stage synchronizer brings in the asynchronous active-high ready input. A low ready at the end of T3 inserts wait states before T4. Read data is taken from the lanes at the end of T4, and the response pulses for one clock. Between cycles, a hold request floats the shared lanes and the address bus, and the hold acknowledge rises one clock later. While reset is asserted, every output enable is off and the strobe is driven low. The last bus value sampled before reset is released is kept as a configuration word. The strap sampled at the same moment decides whether the shared lanes carry the address in T1.

Request port rules: the core holds `req_valid` and every request field steady until a clock edge where `req_ready` is high. That edge is the transfer. The 20-bit address bus samples `req_addr` at the falling edge just before that rising edge. `req_ready` is high only when the controller is idle, out of reset, with no hold requested or acknowledged. The response port has no back-pressure: `rsp_valid` is a one-clock pulse, and the core must take `rsp_rdata` in that cycle.

Top module: `muxbus_ctrl`

## Requirements
- R1: An accepted request runs T1, T2, T3, T4 on consecutive clocks when ready is high. `rsp_valid` is high for exactly one clock, in the clock after T4. `req_ready` is low from T1 until the controller is idle again.
- R2: `a_out` takes the accepted `req_addr` at the falling clock edge before T1. It is therefore valid half a clock before the shared lanes carry the address. During that half clock, `ad_oe` is still 0.
- R3: `ale` is 1 in the first half of T1 and 0 from mid-T1 onwards. When the address phase is enabled, `ad_out` holds `req_addr[15:0]` steady through the whole of T1.
- R4: In T2, T3, wait states and T4 of a write, `wen[i]` = `req_be[i]`. Bit 1 is the high byte lane `ad_out[15:8]` and bit 0 is the low byte lane `ad_out[7:0]`. `ad_oe[i]` equals `wen[i]`, and a driven lane carries the matching write-data byte. In a read, both `wen` bits and both `ad_oe` bits are 0 in these states.
- R5: If `aden_strap_n` is 0 at the release of reset, both `ad_oe` bits are 1 in T1. If it is 1, both are 0 in T1.
- R6: `cfg_word` holds the `ad_in` value sampled at the last rising clock edge before `rst_n` is released.
- R7: `ardy` passes through two flops. Each clock that the synchronized ready is low at the end of T3 or of a wait state adds one wait state before T4. If `ardy` rises w clocks after T1 (w ≥ 1), the cycle has exactly w wait states.
- R8: For a read, `rsp_rdata` carries the value on `ad_in` at the end of T4.
- R9: `hold_req` is served only when idle, and a request made during a cycle waits for T4 to finish. In the first hold clock, `a_out` and both lanes are floated (`a_oe`=0, `ad_oe`=0) while `hold_ack` is still 0. `hold_ack` rises one clock later. After `hold_req` drops, the outputs stay floated for as long as `hold_ack` is high. The controller accepts no request during hold.
- R10: While `rst_n` is low, `a_oe`, `ad_oe`, `hold_ack` and `rsp_valid` are 0, and `ale` is driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | 20 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 = high lane |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data |
| ad_out | output | 16 | Shared lanes, driven value |
| ad_oe | output | 2 | Per-lane output enable, bit 1 = high lane |
| ad_in | input | 16 | Shared lanes, sampled value |
| a_out | output | 20 | Non-multiplexed address |
| a_oe | output | 1 | Enable for a_out |
| ale | output | 1 | Address-latch strobe |
| wen | output | 2 | Byte-lane write enables, bit 1 = high lane |
| ardy | input | 1 | Asynchronous ready, active high |
| hold_req | input | 1 | Bus hold request |
| hold_ack | output | 1 | Bus hold granted |
| aden_strap_n | input | 1 | Address-phase strap, sampled in reset |
| cfg_word | output | 16 | Configuration captured in reset |

## Verification
The assertions check on every cycle:
- the response pulse lasts one clock;
- T2 follows T1;
- an idle lane without its write enable floats;
- a disabled address phase keeps both lanes off in T1;
- a low synchronized ready leads into a wait state;
- every output floats while hold is acknowledged, and the acknowledge is raised only out of the hold state.

Only the bench scenarios can show the other behaviours:
- the half-clock lead of the address bus and the mid-T1 fall of the strobe;
- the exact count of wait states after a late ready;
- the read data and the captured configuration word;
- that a hold request made during a cycle is deferred until the cycle has ended.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_T3, ST_TW, ST_T4, ST_HOLD
  } bus_st_e;
endpackage

// File: rtl/muxbus_sync.sv
module muxbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], async_in};
  end

  assign sync_out = sh[STAGES-1];
endmodule

// File: rtl/muxbus_cfg.sv
module muxbus_cfg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ad_in,
  input  logic              aden_strap_n,
  output logic [DATA_W-1:0] cfg_word,
  output logic              aden_en
);
  // Loads on every clock while reset is held; the last load before release stays.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_word <= ad_in;
      aden_en  <= !aden_strap_n;
    end
  end
endmodule

// File: rtl/muxbus_fsm.sv
module muxbus_fsm
  import muxbus_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DATA_W-1:0] req_addr_lo,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic              rdy_s,
  input  logic              hold_req,
  input  logic [DATA_W-1:0] ad_in,
  output bus_st_e           state,
  output logic              req_ready,
  output logic              accept,
  output logic              run_q,
  output logic              hold_ack,
  output logic [DATA_W-1:0] addr_q,
  output logic              write_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  be_q,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  bus_st_e nxt;

  assign req_ready = run_q && (state == ST_IDLE) && !hold_req && !hold_ack;
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (run_q && hold_req) nxt = ST_HOLD;
               else if (accept)       nxt = ST_T1;
      ST_T1:   nxt = ST_T2;
      ST_T2:   nxt = ST_T3;
      ST_T3,
      ST_TW:   nxt = rdy_s ? ST_T4 : ST_TW;
      ST_T4:   nxt = ST_IDLE;
      ST_HOLD: if (!hold_req) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      run_q     <= 1'b0;
      hold_ack  <= 1'b0;
      addr_q    <= '0;
      write_q   <= 1'b0;
      wdata_q   <= '0;
      be_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state     <= nxt;
      run_q     <= 1'b1;
      hold_ack  <= (state == ST_HOLD);
      rsp_valid <= (state == ST_T4);
      if (accept) begin
        addr_q  <= req_addr_lo;
        write_q <= req_write;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
      if (state == ST_T4 && !write_q) rsp_rdata <= ad_in;
    end
  end
endmodule

// File: rtl/muxbus_lanes.sv
module muxbus_lanes
  import muxbus_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  bus_st_e           state,
  input  logic              run_q,
  input  logic              aden_en,
  input  logic [DATA_W-1:0] addr_q,
  input  logic              write_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic [LANES-1:0]  be_q,
  output logic [DATA_W-1:0] ad_out,
  output logic [LANES-1:0]  ad_oe,
  output logic [LANES-1:0]  wen
);
  logic addr_ph, data_ph;

  assign addr_ph = (state == ST_T1);
  assign data_ph = (state == ST_T2) || (state == ST_T3) ||
                   (state == ST_TW) || (state == ST_T4);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign wen[i]          = data_ph && write_q && be_q[i];
    assign ad_oe[i]        = run_q && ((addr_ph && aden_en) || wen[i]);
    assign ad_out[i*8 +: 8] = addr_ph ? addr_q[i*8 +: 8] : wdata_q[i*8 +: 8];
  end
endmodule

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
  import muxbus_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LANES      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W-1:0] ad_out,
  output logic [LANES-1:0]  ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [ADDR_W-1:0] a_out,
  output logic              a_oe,
  output logic              ale,
  output logic [LANES-1:0]  wen,
  input  logic              ardy,
  input  logic              hold_req,
  output logic              hold_ack,
  input  logic              aden_strap_n,
  output logic [DATA_W-1:0] cfg_word
);
  bus_st_e           state;
  logic              rdy_s, accept, run_q, aden_en, write_q, ale_mid;
  logic [DATA_W-1:0] addr_q, wdata_q;
  logic [LANES-1:0]  be_q;

  muxbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ardy), .sync_out(rdy_s)
  );

  muxbus_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .aden_strap_n(aden_strap_n),
    .cfg_word(cfg_word), .aden_en(aden_en)
  );

  muxbus_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_addr_lo(req_addr[DATA_W-1:0]), .req_write(req_write),
    .req_wdata(req_wdata), .req_be(req_be), .rdy_s(rdy_s),
    .hold_req(hold_req), .ad_in(ad_in), .state(state),
    .req_ready(req_ready), .accept(accept), .run_q(run_q),
    .hold_ack(hold_ack), .addr_q(addr_q), .write_q(write_q),
    .wdata_q(wdata_q), .be_q(be_q), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  muxbus_lanes #(.DATA_W(DATA_W)) u_lanes (
    .state(state), .run_q(run_q), .aden_en(aden_en), .addr_q(addr_q),
    .write_q(write_q), .wdata_q(wdata_q), .be_q(be_q),
    .ad_out(ad_out), .ad_oe(ad_oe), .wen(wen)
  );

  // The address bus moves on the falling edge ahead of T1.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)      a_out <= '0;
    else if (accept) a_out <= req_addr;
  end

  // The strobe falls at mid-T1.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ale_mid <= 1'b0;
    else        ale_mid <= (state == ST_T1);
  end

  assign ale  = (state == ST_T1) && !ale_mid;
  assign a_oe = run_q && (state != ST_HOLD) && !hold_ack;
endmodule

// File: rtl/muxbus_ctrl_chk.sv
module muxbus_ctrl_chk
  import muxbus_pkg::*;
#(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input bus_st_e          state,
  input logic             rdy_s,
  input logic             aden_en,
  input logic             rsp_valid,
  input logic             hold_ack,
  input logic             a_oe,
  input logic [LANES-1:0] ad_oe,
  input logic [LANES-1:0] wen
);
  logic in_data;
  assign in_data = (state == ST_T2) || (state == ST_T3) ||
                   (state == ST_TW) || (state == ST_T4);

  p_ack_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_t2_after_t1_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_T2) |-> ($past(state) == ST_T1));

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    p_lane_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data && !wen[i]) |-> !ad_oe[i]);
  end

  p_aden_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_T1) && !aden_en) |-> (ad_oe == '0));

  p_wait_insert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (((state == ST_T3) || (state == ST_TW)) && !rdy_s) |=> (state == ST_TW));

  p_hold_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (!a_oe && (ad_oe == '0)));

  p_hold_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> ($past(state) == ST_HOLD));
endmodule

bind muxbus_ctrl muxbus_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .rdy_s(rdy_s),
  .aden_en(aden_en), .rsp_valid(rsp_valid), .hold_ack(hold_ack),
  .a_oe(a_oe), .ad_oe(ad_oe), .wen(wen)
);

// File: tb/tb_muxbus_ctrl.sv
`timescale 1ns/1ps
module tb_muxbus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic        rsp_valid;
  logic [15:0] rsp_rdata, ad_out, ad_in, cfg_word;
  logic [1:0]  ad_oe, wen;
  logic [19:0] a_out;
  logic        a_oe, ale, ardy, hold_req, hold_ack, aden_strap_n;

  int vectors = 0;
  int miscompares = 0;
  bit aden_exp;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  muxbus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_out(a_out),
    .a_oe(a_oe), .ale(ale), .wen(wen), .ardy(ardy), .hold_req(hold_req),
    .hold_ack(hold_ack), .aden_strap_n(aden_strap_n), .cfg_word(cfg_word)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #3;
  endtask

  task automatic do_reset(input logic strap_n, input logic [15:0] cfg);
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; req_be = '0; ardy = 1'b1; hold_req = 1'b0;
    ad_in = cfg; aden_strap_n = strap_n;
    repeat (3) tick();
    chk("R10 a_oe in reset", a_oe, 0);
    chk("R10 ad_oe in reset", ad_oe, 0);
    chk("R10 ale driven low in reset", ale, 0);
    chk("R10 hold_ack in reset", hold_ack, 0);
    chk("R10 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    tick();
    chk("R6 cfg_word capture", cfg_word, cfg);
    chk("R10 a_oe after reset", a_oe, 1);
    chk("R1 req_ready after reset", req_ready, 1);
    ad_in = 16'h0000;
    aden_exp = !strap_n;
  endtask

  // Starts at posedge+3 while idle; ends at posedge+3 one clock after the response.
  task automatic run_cycle(input logic wr, input logic [19:0] addr, input logic [15:0] wd,
                           input logic [1:0] be, input int w, input logic [15:0] rd,
                           input int hold_k);
    logic [1:0] exp_wen;
    exp_wen = wr ? be : 2'b00;
    chk("R1 req_ready idle", req_ready, 1);
    req_valid = 1'b1; req_addr = addr; req_write = wr; req_wdata = wd; req_be = be;
    if (w > 0) ardy = 1'b0;
    #4;
    chk("R2 a_out leads shared bus", a_out, addr);
    chk("R2 lanes not yet driven", ad_oe, 0);
    @(posedge clk); #3;
    chk("R3 ale high early T1", ale, 1);
    chk("R5 T1 lane enables", ad_oe, aden_exp ? 2'b11 : 2'b00);
    if (aden_exp) chk("R3 address on lanes", ad_out, addr[15:0]);
    chk("R1 req_ready low in T1", req_ready, 0);
    req_valid = 1'b0;
    #4;
    chk("R3 ale low mid T1", ale, 0);
    if (aden_exp) chk("R3 address stable at ale fall", ad_out, addr[15:0]);
    @(posedge clk); #3;
    for (int k = 1; k <= 5 + w; k++) begin
      if (k <= 3 + w) begin
        chk("R4 wen in data states", wen, exp_wen);
        chk("R4 lane enables follow wen", ad_oe, exp_wen);
        if (exp_wen[0]) chk("R4 low lane data", ad_out[7:0], wd[7:0]);
        if (exp_wen[1]) chk("R4 high lane data", ad_out[15:8], wd[15:8]);
        chk("R7 no response before T4 ends", rsp_valid, 0);
        if (hold_k > 0 && k > hold_k) begin
          chk("R9 hold deferred a_oe", a_oe, 1);
          chk("R9 hold deferred ack", hold_ack, 0);
        end
      end else if (k == 4 + w) begin
        chk("R7 response after wait states", rsp_valid, 1);
        if (!wr) chk("R8 read data", rsp_rdata, rd);
        chk("R4 lanes float when idle", ad_oe, 0);
      end else begin
        chk("R1 response one clock", rsp_valid, 0);
        if (hold_k > 0) begin
          chk("R9 float in first hold clock", a_oe, 0);
          chk("R9 ack not yet", hold_ack, 0);
        end
      end
      if (k == 1 && !wr) ad_in = rd;
      if (k == w) ardy = 1'b1;
      if (k == hold_k) hold_req = 1'b1;
      if (k < 5 + w) tick();
    end
    ardy = 1'b1;
  endtask

  task automatic t_hold_idle();
    hold_req = 1'b1;
    tick();
    chk("R9 float at hold entry a_oe", a_oe, 0);
    chk("R9 float at hold entry ad_oe", ad_oe, 0);
    chk("R9 ack one clock later", hold_ack, 0);
    chk("R9 no accept in hold", req_ready, 0);
    tick();
    chk("R9 hold_ack raised", hold_ack, 1);
    chk("R9 ale driven low in hold", ale, 0);
    req_valid = 1'b1; req_addr = 20'hFFFFF;
    tick();
    chk("R9 request ignored in hold", req_ready, 0);
    chk("R9 no address phase in hold", ale, 0);
    hold_req = 1'b0; req_valid = 1'b0;
    tick();
    chk("R9 ack held after release", hold_ack, 1);
    chk("R9 float while ack high", a_oe, 0);
    tick();
    chk("R9 ack dropped", hold_ack, 0);
    chk("R9 a_oe back", a_oe, 1);
    chk("R9 a_out untouched by ignored request", a_out, 20'h4_5678);
  endtask

  task automatic t_hold_mid();
    run_cycle(1'b0, 20'hB_1357, 16'h0, 2'b11, 3, 16'hD00D, 1);
    tick();
    chk("R9 hold_ack after deferred hold", hold_ack, 1);
    hold_req = 1'b0;
    tick(); tick();
    chk("R9 released", hold_ack, 0);
    chk("R9 req_ready after release", req_ready, 1);
  endtask

  initial begin
    do_reset(1'b0, 16'hA5C3);
    run_cycle(1'b0, 20'h1_2A4C, 16'h0, 2'b11, 0, 16'hBEEF, 0);
    run_cycle(1'b1, 20'h8_0F0E, 16'hCAFE, 2'b11, 2, 16'h0, 0);
    run_cycle(1'b1, 20'h2_2222, 16'h9A5B, 2'b10, 1, 16'h0, 0);
    run_cycle(1'b0, 20'h4_5678, 16'h0, 2'b11, 5, 16'h3C69, 0);
    t_hold_idle();
    t_hold_mid();
    do_reset(1'b1, 16'h5A3C);
    run_cycle(1'b1, 20'hF_EDCB, 16'h1234, 2'b01, 0, 16'h0, 0);
    run_cycle(1'b0, 20'h0_0001, 16'h0, 2'b11, 0, 16'h7E81, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule